// File: doc/BRIEF.md
# Gated Input Edge Timestamper

This block serves one real-time input line. Software opens a listening window by giving a start time and a length, both measured on a free-running wall-clock counter that the block receives as an input. The raw input is synchronised, and rising edges are detected. Every rising edge seen while the window is open is stored in a bounded FIFO, tagged with the wall-clock value of the cycle in which the block saw it.

A reader has two requests. A pop removes the oldest timestamp. A count request gives a limit time. It stays pending until the wall clock has moved past that limit, then removes and counts every stored stamp at or below the limit. If an edge arrives while the FIFO is full, that edge is lost. The loss is held as a pending overflow and is reported with the next response. A synchronous flush input empties the FIFO and clears all pending state.

Top module: `gated_edge_stamper`

## Requirements
- R1: When reset is released, rsp_done_o, rsp_valid_o, rsp_ovf_o, rd_busy_o, win_open_o and win_refused_o are all low, and the FIFO is empty.
- R2: sig_i passes through SYNC_STAGES flops. A rise is seen SYNC_STAGES cycles after the first clock edge that samples sig_i high. The stamp stored is the wall_i value of the cycle in which the rise is seen. Falling edges and steady levels store nothing.
- R3: A window request (win_req_i) is accepted when win_start_i > wall_i. After that, win_open_o is high exactly while win_start_i <= wall_i < win_start_i + win_len_i. Rises seen while win_open_o is low are not stored.
- R4: A window request with win_start_i <= wall_i is refused. win_refused_o pulses high for one cycle after the request, and the previous window stays unchanged.
- R5: The FIFO holds up to DEPTH stamps. A rise seen in an open window while the FIFO is full is dropped and sets a pending overflow.
- R6: A pending overflow appears on rsp_ovf_o with the next response and is then cleared, unless a new overflow occurs in that same cycle.
- R7: A pop is rd_req_i with rd_count_i=0. On a non-empty FIFO, the next cycle brings a one-cycle rsp_done_o with rsp_valid_o=1, rsp_stamp_o set to the oldest stamp and rsp_count_o=0, and that entry is removed.
- R8: A pop on an empty FIFO returns rsp_done_o with rsp_valid_o=0 and rsp_stamp_o=0. It never blocks.
- R9: A count is rd_req_i with rd_count_i=1 and limit rd_limit_i. rd_busy_o is high from the next cycle. Nothing is removed until wall_i > limit. After that, stamps <= limit are removed one per cycle, and then the response arrives with rsp_valid_o=1, rsp_count_o set to the number removed and rsp_stamp_o=0.
- R10: flush_i empties the FIFO, clears the pending overflow and aborts a pending count. rd_busy_o is low in the next cycle, and no response is produced.
- R11: rd_req_i is ignored while rd_busy_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wall_i | input | TS_W | Wall-clock counter value |
| flush_i | input | 1 | Synchronous clear of FIFO, overflow and pending count |
| sig_i | input | 1 | Raw asynchronous input line |
| win_req_i | input | 1 | Window request strobe |
| win_start_i | input | TS_W | Window start time |
| win_len_i | input | TS_W | Window length in wall-clock ticks |
| win_open_o | output | 1 | Window currently open |
| win_refused_o | output | 1 | Last window request refused (start not in future) |
| rd_req_i | input | 1 | Read request strobe |
| rd_count_i | input | 1 | 0 = pop, 1 = count up to limit |
| rd_limit_i | input | TS_W | Limit time for a count |
| rd_busy_o | output | 1 | Count pending |
| rsp_done_o | output | 1 | Response strobe |
| rsp_valid_o | output | 1 | Response carries data |
| rsp_stamp_o | output | TS_W | Popped stamp |
| rsp_count_o | output | CNT_W | Number of stamps counted |
| rsp_ovf_o | output | 1 | Overflow occurred before this response |

## Verification
The hardest state to reach is a count that is still waiting for the wall clock while new edges arrive with stamps below its limit. At the same moment, a pop is issued that must be ignored, and the FIFO still holds entries from before the count. The bench opens one long window and overfills it so that an overflow is pending. It then issues a count with a limit about thirty ticks in the future, pulses the input twice during the wait, and drives a pop in the middle. Finally, a second count is aborted by flush while the FIFO is full and an overflow is pending, to show that all three pieces of state clear together.

// File: rtl/es_pkg.sv
package es_pkg;
  typedef enum logic [0:0] {RD_IDLE, RD_WAIT} rd_state_e;
endpackage

// File: rtl/es_sync_rise.sv
module es_sync_rise #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o
);
  // pipe_q[STAGES-1] is the synchronised level, pipe_q[STAGES] its previous value
  logic [STAGES:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-1:0], sig_i};
  end

  assign rise_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];
endmodule

// File: rtl/es_gate.sv
module es_gate #(
  parameter int TS_W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [TS_W-1:0] wall_i,
  input  logic            req_i,
  input  logic [TS_W-1:0] start_i,
  input  logic [TS_W-1:0] len_i,
  output logic            open_o,
  output logic            refused_o
);
  logic            armed_q;
  logic [TS_W-1:0] start_q, end_q;
  logic            accept;

  assign accept = req_i && (start_i > wall_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q   <= 1'b0;
      start_q   <= '0;
      end_q     <= '0;
      refused_o <= 1'b0;
    end else begin
      refused_o <= req_i && !accept;
      if (accept) begin
        armed_q <= 1'b1;
        start_q <= start_i;
        end_q   <= start_i + len_i;
      end
    end
  end

  assign open_o = armed_q && (wall_i >= start_q) && (wall_i < end_q);

  a_r4_refused_keeps_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refused_o |-> ($stable(start_q) && $stable(end_q)));
endmodule

// File: rtl/es_fifo.sv
module es_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         flush_i,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         empty_o,
  output logic         full_o
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wptr_q, rptr_q;
  logic [LVL_W-1:0] level_q;
  logic             do_push, do_pop;

  assign empty_o = (level_q == '0);
  assign full_o  = (level_q == LVL_W'(DEPTH));
  assign do_push = push_i && !full_o && !flush_i;
  assign do_pop  = pop_i && !empty_o && !flush_i;
  assign head_o  = mem_q[rptr_q];

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      level_q <= '0;
    end else if (flush_i) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      level_q <= '0;
    end else begin
      if (do_push) wptr_q <= ptr_next(wptr_q);
      if (do_pop)  rptr_q <= ptr_next(rptr_q);
      if (do_push && !do_pop)      level_q <= level_q + LVL_W'(1);
      else if (do_pop && !do_push) level_q <= level_q - LVL_W'(1);
    end
  end

  a_r5_level_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_q <= LVL_W'(DEPTH));
  a_r5_full_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i && !flush_i) |=> full_o);
  a_r7_pop_nonempty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/es_reader.sv
module es_reader import es_pkg::*; #(
  parameter int TS_W  = 32,
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic [TS_W-1:0]  wall_i,
  input  logic             req_i,
  input  logic             count_i,
  input  logic [TS_W-1:0]  limit_i,
  input  logic             empty_i,
  input  logic [TS_W-1:0]  head_i,
  input  logic             ovf_set_i,
  output logic             pop_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             valid_o,
  output logic [TS_W-1:0]  stamp_o,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_o
);
  rd_state_e        state_q, state_d;
  logic [TS_W-1:0]  limit_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ovf_q;
  logic             report, rep_valid, pop;
  logic [TS_W-1:0]  rep_stamp;
  logic [CNT_W-1:0] rep_count;
  logic             take_cnt;

  assign take_cnt = (state_q == RD_IDLE) && req_i && count_i;

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    report    = 1'b0;
    rep_valid = 1'b0;
    rep_stamp = '0;
    rep_count = '0;
    pop       = 1'b0;
    unique case (state_q)
      RD_IDLE: if (req_i) begin
        if (count_i) begin
          state_d = RD_WAIT;
          cnt_d   = '0;
        end else begin
          report    = 1'b1;
          rep_valid = !empty_i;
          rep_stamp = empty_i ? '0 : head_i;
          pop       = !empty_i;
        end
      end
      RD_WAIT: if (wall_i > limit_q) begin
        // drain one stamp per cycle while the head is inside the limit
        if (!empty_i && head_i <= limit_q) begin
          pop   = 1'b1;
          cnt_d = cnt_q + CNT_W'(1);
        end else begin
          report    = 1'b1;
          rep_valid = 1'b1;
          rep_count = cnt_q;
          state_d   = RD_IDLE;
        end
      end
    endcase
  end

  assign pop_o  = pop && !flush_i;
  assign busy_o = (state_q == RD_WAIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RD_IDLE;
      limit_q <= '0;
      cnt_q   <= '0;
      ovf_q   <= 1'b0;
      done_o  <= 1'b0;
      valid_o <= 1'b0;
      stamp_o <= '0;
      count_o <= '0;
      ovf_o   <= 1'b0;
    end else if (flush_i) begin
      state_q <= RD_IDLE;
      cnt_q   <= '0;
      ovf_q   <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_o  <= report;
      ovf_q   <= (ovf_q && !report) || ovf_set_i;
      if (take_cnt) limit_q <= limit_i;
      if (report) begin
        valid_o <= rep_valid;
        stamp_o <= rep_stamp;
        count_o <= rep_count;
        ovf_o   <= ovf_q;
      end
    end
  end

  a_r9_count_after_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && $past(state_q == RD_WAIT)) |-> ($past(wall_i) > limit_q));
  a_r6_ovf_consumed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!ovf_q || $past(ovf_set_i)));
  a_r11_idle_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
endmodule

// File: rtl/gated_edge_stamper.sv
module gated_edge_stamper #(
  parameter int TS_W        = 32,
  parameter int DEPTH       = 8,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [TS_W-1:0]  wall_i,
  input  logic             flush_i,
  input  logic             sig_i,
  input  logic             win_req_i,
  input  logic [TS_W-1:0]  win_start_i,
  input  logic [TS_W-1:0]  win_len_i,
  output logic             win_open_o,
  output logic             win_refused_o,
  input  logic             rd_req_i,
  input  logic             rd_count_i,
  input  logic [TS_W-1:0]  rd_limit_i,
  output logic             rd_busy_o,
  output logic             rsp_done_o,
  output logic             rsp_valid_o,
  output logic [TS_W-1:0]  rsp_stamp_o,
  output logic [CNT_W-1:0] rsp_count_o,
  output logic             rsp_ovf_o
);
  logic            rise, push, full, empty, pop, ovf_set;
  logic [TS_W-1:0] head;

  es_sync_rise #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .sig_i(sig_i), .rise_o(rise)
  );

  es_gate #(.TS_W(TS_W)) u_gate (
    .clk_i(clk_i), .rst_ni(rst_ni), .wall_i(wall_i), .req_i(win_req_i),
    .start_i(win_start_i), .len_i(win_len_i),
    .open_o(win_open_o), .refused_o(win_refused_o)
  );

  assign push    = rise && win_open_o;
  assign ovf_set = push && full && !flush_i;

  es_fifo #(.W(TS_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i(clk_i), .rst_ni(rst_ni), .flush_i(flush_i), .push_i(push),
    .wdata_i(wall_i), .pop_i(pop), .head_o(head), .empty_o(empty), .full_o(full)
  );

  es_reader #(.TS_W(TS_W), .CNT_W(CNT_W)) u_reader (
    .clk_i(clk_i), .rst_ni(rst_ni), .flush_i(flush_i), .wall_i(wall_i),
    .req_i(rd_req_i), .count_i(rd_count_i), .limit_i(rd_limit_i),
    .empty_i(empty), .head_i(head), .ovf_set_i(ovf_set),
    .pop_o(pop), .busy_o(rd_busy_o), .done_o(rsp_done_o), .valid_o(rsp_valid_o),
    .stamp_o(rsp_stamp_o), .count_o(rsp_count_o), .ovf_o(rsp_ovf_o)
  );
endmodule

// File: tb/gated_edge_stamper_test.sv
`timescale 1ns/100ps
module gated_edge_stamper_test;
  localparam int TS_W  = 32;
  localparam int DEPTH = 8;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic [TS_W-1:0] wall = 100;
  logic flush = 0, sig = 0, win_req = 0, rd_req = 0, rd_count = 0;
  logic [TS_W-1:0] win_start = 0, win_len = 0, rd_limit = 0;
  logic win_open, win_refused, rd_busy, rsp_done, rsp_valid, rsp_ovf;
  logic [TS_W-1:0] rsp_stamp;
  logic [CNT_W-1:0] rsp_count;

  int n_checks = 0, n_errs = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) wall <= #1 wall + 1;

  gated_edge_stamper #(.TS_W(TS_W), .DEPTH(DEPTH)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wall_i(wall), .flush_i(flush), .sig_i(sig),
    .win_req_i(win_req), .win_start_i(win_start), .win_len_i(win_len),
    .win_open_o(win_open), .win_refused_o(win_refused),
    .rd_req_i(rd_req), .rd_count_i(rd_count), .rd_limit_i(rd_limit),
    .rd_busy_o(rd_busy), .rsp_done_o(rsp_done), .rsp_valid_o(rsp_valid),
    .rsp_stamp_o(rsp_stamp), .rsp_count_o(rsp_count), .rsp_ovf_o(rsp_ovf)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit m_h1, m_h2, m_h3, m_armed, m_ref, m_wait, m_ovf;
  bit m_done, m_valid, m_rovf;
  logic [TS_W-1:0] m_gs, m_ge, m_lim, m_stamp;
  int m_cnt, m_count;
  logic [TS_W-1:0] mq[$];

  always @(posedge clk or negedge rst_n) begin : model
    bit rise, open_now, full, empty, do_pop, rep, ovf_set;
    if (!rst_n) begin
      {m_h1, m_h2, m_h3, m_armed, m_ref, m_wait, m_ovf} = '0;
      {m_done, m_valid, m_rovf} = '0;
      m_gs = 0; m_ge = 0; m_lim = 0; m_stamp = 0; m_cnt = 0; m_count = 0;
      mq.delete();
    end else begin
      rise     = m_h2 && !m_h3;
      open_now = m_armed && wall >= m_gs && wall < m_ge;
      full     = mq.size() == DEPTH;
      empty    = mq.size() == 0;
      do_pop   = 0;
      rep      = 0;
      if (flush) begin
        mq.delete();
        m_ovf = 0; m_wait = 0; m_cnt = 0; m_done = 0;
      end else begin
        ovf_set = rise && open_now && full;
        if (!m_wait) begin
          if (rd_req && !rd_count) begin
            rep = 1; m_valid = !empty; m_stamp = empty ? '0 : mq[0]; m_count = 0; do_pop = !empty;
          end else if (rd_req) begin
            m_wait = 1; m_lim = rd_limit; m_cnt = 0;
          end
        end else if (wall > m_lim) begin
          if (!empty && mq[0] <= m_lim) begin
            do_pop = 1; m_cnt++;
          end else begin
            rep = 1; m_valid = 1; m_stamp = 0; m_count = m_cnt; m_wait = 0;
          end
        end
        if (rep) m_rovf = m_ovf;
        m_ovf  = (m_ovf && !rep) || ovf_set;
        m_done = rep;
        if (do_pop) void'(mq.pop_front());
        if (rise && open_now && !full) mq.push_back(wall);
      end
      m_ref = win_req && !(win_start > wall);
      if (win_req && win_start > wall) begin
        m_armed = 1; m_gs = win_start; m_ge = win_start + win_len;
      end
      m_h3 = m_h2; m_h2 = m_h1; m_h1 = sig;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    #1;
    if (rst_n && !finished) begin
      chk("R3 win_open_o", win_open, m_armed && wall >= m_gs && wall < m_ge);
      chk("R4 win_refused_o", win_refused, m_ref);
      chk("R9 rd_busy_o", rd_busy, m_wait);
      chk("R7 rsp_done_o", rsp_done, m_done);
      if (m_done) begin
        chk("R7 rsp_valid_o", rsp_valid, m_valid);
        chk("R7 rsp_stamp_o", rsp_stamp, m_stamp);
        chk("R9 rsp_count_o", rsp_count, m_count);
        chk("R6 rsp_ovf_o", rsp_ovf, m_rovf);
      end
    end
  end

  // ---------------- directed stimulus ----------------
  logic [TS_W-1:0] exp_q[$];
  logic [TS_W-1:0] e_gs = 0, e_ge = 0;
  bit e_armed = 0;

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse();
    logic [TS_W-1:0] seen;
    seen = wall + 2;
    if (e_armed && seen >= e_gs && seen < e_ge && exp_q.size() < DEPTH) exp_q.push_back(seen);
    sig = 1; cyc(2); sig = 0; cyc(2);
  endtask

  task automatic open_win(input logic [TS_W-1:0] s, input logic [TS_W-1:0] l);
    if (s > wall) begin e_armed = 1; e_gs = s; e_ge = s + l; end
    win_req = 1; win_start = s; win_len = l;
    cyc(1);
    win_req = 0;
  endtask

  task automatic rd(input bit is_cnt, input logic [TS_W-1:0] lim,
                    output bit v, output logic [TS_W-1:0] st, output int c, output bit ov);
    bit got;
    got = 0; v = 0; st = 0; c = 0; ov = 0;
    rd_req = 1; rd_count = is_cnt; rd_limit = lim;
    @(negedge clk);
    rd_req = 0;
    for (int i = 0; i < 500 && !got; i++) begin
      #1;
      if (rsp_done) begin got = 1; v = rsp_valid; st = rsp_stamp; c = int'(rsp_count); ov = rsp_ovf; end
      @(negedge clk);
    end
    if (!got) chk("R7 response timeout", 0, 1);
  endtask

  initial begin : stim
    bit v, ov;
    logic [TS_W-1:0] st, lim;
    int c, n;
    #12 rst_n = 1;
    @(negedge clk); #1;
    chk("R1 rsp_done_o", rsp_done, 0);
    chk("R1 rsp_valid_o", rsp_valid, 0);
    chk("R1 rsp_ovf_o", rsp_ovf, 0);
    chk("R1 rd_busy_o", rd_busy, 0);
    chk("R1 win_open_o", win_open, 0);
    chk("R1 win_refused_o", win_refused, 0);
    @(negedge clk);
    rd(0, 0, v, st, c, ov);
    chk("R8 empty pop valid", v, 0);
    chk("R8 empty pop stamp", st, 0);

    // R2/R3: window covers middle of a pulse train
    open_win(wall + 12, 40);
    for (int i = 0; i < 14; i++) pulse();
    cyc(6);
    n = exp_q.size();
    chk("R3 some edges in window", n > 3 && n < 14, 1);
    for (int i = 0; i < n; i++) begin
      rd(0, 0, v, st, c, ov);
      chk("R7 pop valid", v, 1);
      chk("R2 stamp equals wall when seen", st, exp_q.pop_front());
    end
    rd(0, 0, v, st, c, ov);
    chk("R3 edges outside window dropped", v, 0);

    // R4: start not in the future
    open_win(wall, 50);
    #1 chk("R4 refused pulse", win_refused, 1);
    cyc(1); #1 chk("R4 refused one cycle", win_refused, 0);
    pulse(); pulse(); cyc(3);
    rd(0, 0, v, st, c, ov);
    chk("R4 old window unchanged", v, 0);

    // R5/R6: overfill
    open_win(wall + 5, 1000);
    cyc(3);
    for (int i = 0; i < DEPTH + 3; i++) pulse();
    cyc(3);
    chk("R5 FIFO holds DEPTH", exp_q.size(), DEPTH);
    rd(0, 0, v, st, c, ov);
    chk("R6 overflow reported", ov, 1);
    chk("R5 oldest kept", st, exp_q.pop_front());
    rd(0, 0, v, st, c, ov);
    chk("R6 overflow cleared", ov, 0);
    void'(exp_q.pop_front());

    // R9: count with limit in the past
    lim = exp_q[2];
    rd(1, lim, v, st, c, ov);
    chk("R9 past-limit count", c, 3);
    chk("R9 count valid", v, 1);
    repeat (3) void'(exp_q.pop_front());
    rd(0, 0, v, st, c, ov);
    chk("R9 later stamp left", st, exp_q.pop_front());

    // R9/R11: count with future limit, edges and a pop during the wait
    lim = wall + 30;
    rd_req = 1; rd_count = 1; rd_limit = lim;
    cyc(1); rd_req = 0;
    #1 chk("R9 busy after count req", rd_busy, 1);
    cyc(3);
    rd_req = 1; rd_count = 0;
    cyc(1); rd_req = 0;
    #1 chk("R11 pop ignored while busy", rsp_done, 0);
    pulse(); pulse();
    n = 0;
    foreach (exp_q[i]) if (exp_q[i] <= lim) n++;
    c = -1;
    for (int i = 0; i < 200 && c < 0; i++) begin
      @(negedge clk); #1;
      if (rsp_done) begin
        c = int'(rsp_count);
        chk("R9 waited for wall", wall > lim + 1, 1);
      end
    end
    chk("R9 future-limit count", c, n);
    repeat (n) void'(exp_q.pop_front());
    @(negedge clk);
    rd(0, 0, v, st, c, ov);
    chk("R9 FIFO drained", v, exp_q.size() != 0);
    exp_q.delete();

    // R10: flush clears FIFO, overflow and a pending count
    for (int i = 0; i < DEPTH + 2; i++) pulse();
    cyc(3);
    rd_req = 1; rd_count = 1; rd_limit = wall + 100;
    cyc(1); rd_req = 0;
    cyc(2);
    flush = 1; cyc(1); flush = 0;
    #1 chk("R10 busy cleared", rd_busy, 0);
    exp_q.delete();
    cyc(4);
    chk("R10 no response after flush", rsp_done, 0);
    rd(0, 0, v, st, c, ov);
    chk("R10 FIFO empty", v, 0);
    chk("R10 overflow cleared", ov, 0);
    cyc(4);

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++; n_errs++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end
endmodule